// File: doc/BRIEF.md
# Auto-Detecting Parallel Host Bus Front End

This block sits between an external host and an internal bank of 8-bit peripheral registers. The host can talk to it in either of two bus styles. In the separate-bus style the register address sits on four dedicated pins. In the shared-bus style the address is carried on the low data lines and is captured with an address latch enable. The block detects the style by itself, by watching the latch-enable pin. It then turns the host's strobes into internal one-cycle register read and write pulses, together with an internal register address and write data.

Every host input passes through a two-stage synchronizer into the internal clock before any decoding. The bidirectional data pad is modelled as an input bus, an output bus and an output enable. The register bank returns read data combinationally from the internal address.

Top module: `hbus_front`

## Requirements
- R1: While reset is applied and right after it, `reg_rd_o`, `reg_wr_o` and `data_oe_o` are low, `reg_addr_o` and `reg_wdata_o` are zero, `data_o` is zero, and the interface is in separate-bus mode.
- R2: In separate-bus mode the register address of an access is taken from `addr_i`, and `data_i` bits 3..0 are not used as the address. The block stays in this mode while `ale_i` shows no rising edge.
- R3: A rising edge on `ale_i` switches the interface to shared-bus mode.
- R4: In shared-bus mode, every falling edge of `ale_i` captures `data_i[3:0]` as the register address, whatever level `cs_ni` has at that time. The captured address is used for later accesses in place of `addr_i`.
- R5: In shared-bus mode, a rising edge of `cs_ni` (release) returns the interface to separate-bus mode, and so does reset.
- R6: In shared-bus mode a read is active while `cs_ni` and `rd_ni` are both low, and a write is active while `cs_ni` and `wr_ni` are both low. With `cs_ni` high no strobe is produced.
- R7: In separate-bus mode an access is enabled only while `cs_ni` and `wr_ni` are both low. `rd_ni` then gives the direction: 1 means read, 0 means write.
- R8: Each write produces exactly one single-cycle `reg_wr_o` pulse. The pulse appears after the third rising clock edge that follows the end of the write. During the pulse, `reg_addr_o` and `reg_wdata_o` hold the address and data that were present during the access.
- R9: Each read produces one single-cycle `reg_rd_o` pulse. From the third rising edge after the read starts, `data_oe_o` is high and `reg_addr_o` holds the read address. `data_oe_o` stays high only while the read is active and goes low by the third edge after the read ends. `data_o` equals `reg_rdata_i` while `data_oe_o` is high and is zero otherwise.
- R10: If `ale_i` is held high through reset and afterwards (tied high), the interface stays in separate-bus mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Host chip select, active low |
| ale_i | input | 1 | Host address latch enable |
| rd_ni | input | 1 | Read strobe (shared) or direction select (separate) |
| wr_ni | input | 1 | Write strobe (shared) or access enable (separate), active low |
| addr_i | input | 4 | Dedicated address pins, separate-bus mode |
| data_i | input | 8 | Data pad input; low nibble carries the address in shared-bus mode |
| data_o | output | 8 | Data pad output |
| data_oe_o | output | 1 | Data pad output enable |
| reg_rd_o | output | 1 | Internal register read pulse |
| reg_wr_o | output | 1 | Internal register write pulse |
| reg_addr_o | output | 4 | Internal register address |
| reg_wdata_o | output | 8 | Internal register write data |
| reg_rdata_i | input | 8 | Read data returned by the register bank |

## Verification
Every result goes through the same path: two synchronizer stages, then one output register. A read pulse, its output enable and its data are therefore due after the third rising edge following the strobe assertion, and a write pulse after the third rising edge following the strobe release. The driver changes inputs on falling edges and records the current edge count, and each scoreboard entry carries a due count of that value plus three. The monitor samples on falling edges and compares the pulse kind, address, data and the exact edge count when it pops an entry. Strobe sequences that must produce nothing are checked by confirming that the pulse count does not change.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef enum logic {
    BUS_SEP = 1'b0,
    BUS_MUX = 1'b1
  } bus_mode_e;

  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned CTRL_W      = 4; // ale, cs, rd, wr
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= RST_VAL;
      else         stg[s] <= (s == 0) ? d_i : stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/hbus_mode_ctl.sv
module hbus_mode_ctl
  import hbus_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ale_s_i,
  input  logic          cs_ns_i,
  input  logic [AW-1:0] dlo_s_i,
  output bus_mode_e     mode_o,
  output logic [AW-1:0] lat_addr_o
);
  logic ale_q, cs_q;
  logic ale_rise, ale_fall, cs_rel;

  // references reset high: tied-high ALE never shows a rising edge
  assign ale_rise = ale_s_i & ~ale_q;
  assign ale_fall = ~ale_s_i & ale_q;
  assign cs_rel   = cs_ns_i & ~cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ale_q      <= 1'b1;
      cs_q       <= 1'b1;
      mode_o     <= BUS_SEP;
      lat_addr_o <= '0;
    end else begin
      ale_q <= ale_s_i;
      cs_q  <= cs_ns_i;
      if (ale_rise)    mode_o <= BUS_MUX;
      else if (cs_rel) mode_o <= BUS_SEP;
      if (mode_o == BUS_MUX && ale_fall) lat_addr_o <= dlo_s_i;
    end
  end
endmodule

// File: rtl/hbus_access.sv
module hbus_access
  import hbus_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  bus_mode_e     mode_i,
  input  logic          cs_ns_i,
  input  logic          rd_ns_i,
  input  logic          wr_ns_i,
  input  logic [AW-1:0] addr_s_i,
  input  logic [AW-1:0] lat_addr_i,
  input  logic [DW-1:0] data_s_i,
  output logic          reg_rd_o,
  output logic          reg_wr_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic          rd_oe_o
);
  logic          is_mux;
  logic          ract, wact, ract_q, wact_q;
  logic [AW-1:0] addr_cur;

  assign is_mux   = (mode_i == BUS_MUX);
  assign ract     = ~cs_ns_i & (is_mux ? ~rd_ns_i : (~wr_ns_i & rd_ns_i));
  assign wact     = ~cs_ns_i & ~wr_ns_i & (is_mux | ~rd_ns_i);
  assign addr_cur = is_mux ? lat_addr_i : addr_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ract_q      <= 1'b0;
      wact_q      <= 1'b0;
      reg_rd_o    <= 1'b0;
      reg_wr_o    <= 1'b0;
      rd_oe_o     <= 1'b0;
      reg_addr_o  <= '0;
      reg_wdata_o <= '0;
    end else begin
      ract_q   <= ract;
      wact_q   <= wact;
      reg_rd_o <= ract & ~ract_q;
      reg_wr_o <= wact_q & ~wact;   // write commits on strobe release
      rd_oe_o  <= ract;
      if (ract | wact) reg_addr_o  <= addr_cur;
      if (wact)        reg_wdata_o <= data_s_i;
    end
  end
endmodule

// File: rtl/hbus_front.sv
module hbus_front
  import hbus_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          ale_i,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          reg_rd_o,
  output logic          reg_wr_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  input  logic [DW-1:0] reg_rdata_i
);
  localparam int unsigned SW = CTRL_W + AW + DW;
  localparam logic [SW-1:0] SYNC_RST = {4'b1111, {(AW+DW){1'b0}}};

  logic [SW-1:0] raw, syn;
  logic          ale_s, cs_ns, rd_ns, wr_ns;
  logic [AW-1:0] addr_s, lat_addr;
  logic [DW-1:0] data_s;
  bus_mode_e     mode;

  assign raw = {ale_i, cs_ni, rd_ni, wr_ni, addr_i, data_i};
  assign {ale_s, cs_ns, rd_ns, wr_ns, addr_s, data_s} = syn;

  hbus_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  hbus_mode_ctl #(.AW(AW)) u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ale_s_i   (ale_s),
    .cs_ns_i   (cs_ns),
    .dlo_s_i   (data_s[AW-1:0]),
    .mode_o    (mode),
    .lat_addr_o(lat_addr)
  );

  hbus_access #(.AW(AW), .DW(DW)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .cs_ns_i    (cs_ns),
    .rd_ns_i    (rd_ns),
    .wr_ns_i    (wr_ns),
    .addr_s_i   (addr_s),
    .lat_addr_i (lat_addr),
    .data_s_i   (data_s),
    .reg_rd_o   (reg_rd_o),
    .reg_wr_o   (reg_wr_o),
    .reg_addr_o (reg_addr_o),
    .reg_wdata_o(reg_wdata_o),
    .rd_oe_o    (data_oe_o)
  );

  assign data_o = data_oe_o ? reg_rdata_i : '0;
endmodule

// File: rtl/hbus_front_chk.sv
module hbus_front_chk #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_rd_o,
  input logic          reg_wr_o,
  input logic          data_oe_o,
  input logic [AW-1:0] reg_addr_o,
  input logic [DW-1:0] reg_wdata_o
);
  a_r8_wr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o);

  a_r9_rd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |=> !reg_rd_o);

  a_r9_rd_has_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |-> data_oe_o);

  a_r8_wdata_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> $stable(reg_wdata_o));

  a_r8_waddr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> $stable(reg_addr_o));

  a_r1_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |-> (!reg_rd_o && !reg_wr_o && !data_oe_o));
endmodule

bind hbus_front hbus_front_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/hbus_front_tb_top.sv
module hbus_front_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, ale, rd_n, wr_n;
  logic [3:0] addr;
  logic [7:0] din, dout, wdata, rdata;
  logic       oe, rpls, wpls;
  logic [3:0] raddr;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int pulses = 0;

  typedef struct {
    bit       is_wr;
    bit [3:0] a;
    bit [7:0] d;
    int       due;
  } item_t;
  item_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  assign rdata = {~raddr, raddr};

  hbus_front dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ale_i(ale), .rd_ni(rd_n),
    .wr_ni(wr_n), .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(oe),
    .reg_rd_o(rpls), .reg_wr_o(wpls), .reg_addr_o(raddr),
    .reg_wdata_o(wdata), .reg_rdata_i(rdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && (rpls || wpls)) begin
      pulses++;
      if (q.size() == 0) begin
        check(1'b0, "R8/R9", "unexpected strobe", {30'd0, wpls, rpls}, 32'd0);
      end else begin
        item_t it;
        logic [7:0] got_d;
        it = q.pop_front();
        got_d = it.is_wr ? wdata : dout;
        check(wpls == it.is_wr && rpls == !it.is_wr && raddr == it.a &&
              got_d == it.d && cyc == it.due && (it.is_wr || oe),
              it.is_wr ? "R8" : "R9", "strobe kind/addr/data/cycle",
              {cyc[15:0], raddr, got_d, 3'd0, wpls},
              {it.due[15:0], it.a, it.d, 3'd0, it.is_wr});
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input bit w, input logic [3:0] a, input logic [7:0] d);
    item_t it;
    it.is_wr = w; it.a = a; it.d = d; it.due = cyc + 3;
    q.push_back(it);
  endtask

  task automatic sep_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; rd_n = 1'b0; cs_n = 1'b0; wr_n = 1'b0;
    idle(4);
    cs_n = 1'b1; wr_n = 1'b1;
    push(1'b1, a, d);           // R7 low rd_ni selects write
    idle(6);
    rd_n = 1'b1;
    idle(2);
  endtask

  task automatic sep_read(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; rd_n = 1'b1; cs_n = 1'b0; wr_n = 1'b0;
    push(1'b0, a, {~a, a});     // R7 high rd_ni selects read
    idle(5);
    check(oe == 1'b1, "R9", "oe during read", {31'd0, oe}, 32'd1);
    cs_n = 1'b1; wr_n = 1'b1;
    idle(3);
    check(oe == 1'b0 && dout == 8'd0, "R9", "oe/data after read",
          {23'd0, oe, dout}, 32'd0);
    idle(3);
  endtask

  task automatic mux_latch(input logic [3:0] a);
    @(negedge clk);
    ale = 1'b1; din = {4'h5, a}; addr = ~a;
    idle(3);
    ale = 1'b0;
    idle(3);
    din = 8'hF0 ^ {4'h0, ~a};
  endtask

  task automatic mux_write(input logic [3:0] a, input logic [7:0] d);
    mux_latch(a);
    din = d; cs_n = 1'b0; wr_n = 1'b0;
    idle(4);
    cs_n = 1'b1; wr_n = 1'b1;
    push(1'b1, a, d);
    idle(6);
  endtask

  task automatic mux_read(input logic [3:0] a);
    mux_latch(a);
    cs_n = 1'b0; rd_n = 1'b0;
    push(1'b0, a, {~a, a});
    idle(5);
    cs_n = 1'b1; rd_n = 1'b1;
    idle(6);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(1);
    check(!rpls && !wpls && !oe && raddr == 4'd0 && wdata == 8'd0 && dout == 8'd0,
          "R1", "outputs in reset", {18'd0, rpls, wpls, oe, raddr, wdata, 1'b0},
          32'd0);
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check(!rpls && !wpls && !oe && raddr == 4'd0 && wdata == 8'd0,
          "R1", "outputs after reset", {19'd0, rpls, wpls, oe, raddr, wdata},
          32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    int p0;
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; addr = '0; din = '0;
    ale = 1'b1;                 // R10: ALE tied high from reset
    rst_n = 1'b0;
    idle(2);
    do_reset();
    idle(8);
    sep_read(4'h3, 8'hA5);      // R10 R2: address from addr_i
    ale = 1'b0;                 // ALE falls, no rising edge: stays separate
    idle(8);

    sep_write(4'h6, 8'h5C);     // R7 R8 R2
    sep_read(4'h9, 8'h0C);      // R7 R9 R2

    // R7: enables missing, no strobe
    p0 = pulses;
    @(negedge clk); cs_n = 1'b0; wr_n = 1'b1; rd_n = 1'b0; idle(6);
    cs_n = 1'b1; wr_n = 1'b0; rd_n = 1'b1; idle(6);
    wr_n = 1'b1; idle(6);
    check(pulses == p0 && q.size() == 0, "R7", "no strobe without cs and wr",
          pulses, p0);

    mux_write(4'hB, 8'hC3);     // R3 R4 R6: latched address used
    sep_read(4'h2, 8'h0B);      // R5: cs release returned separate mode

    mux_read(4'hD);             // R6 R9 in shared mode

    // R6: cs high, rd low in shared mode gives nothing
    p0 = pulses;
    mux_latch(4'h1);
    rd_n = 1'b0; idle(6); rd_n = 1'b1;
    wr_n = 1'b0; idle(6); wr_n = 1'b1; idle(6);
    check(pulses == p0 && q.size() == 0, "R6", "no strobe while cs high",
          pulses, p0);

    // R4: latch on every ALE fall while cs held low
    @(negedge clk); cs_n = 1'b0;
    mux_latch(4'h7);
    rd_n = 1'b0; push(1'b0, 4'h7, {~4'h7, 4'h7}); idle(5); rd_n = 1'b1; idle(4);
    mux_latch(4'hE);
    rd_n = 1'b0; push(1'b0, 4'hE, {~4'hE, 4'hE}); idle(5); rd_n = 1'b1; idle(4);
    cs_n = 1'b1;
    idle(6);

    // R5: reset leaves shared mode
    mux_latch(4'h4);
    do_reset();
    idle(4);
    sep_read(4'h8, 8'h04);

    idle(10);
    check(q.size() == 0, "R8/R9", "all expected strobes seen", q.size(), 32'd0);
    finish_run();
  end
endmodule